// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt request lines from several devices together with one non-maskable input and turns them into a single interrupt request to the CPU. It picks the most urgent pending source and takes it only if that source outranks the level the CPU is running at. When the CPU agrees to take the interrupt, the block acknowledges the chosen device and waits for that device to return a vector. It then produces a handler-table address and raises the running level. If the device stays silent for too long, the block reports a bus error instead.

Each handler entry saves the interrupted level on a small internal stack. An end-of-interrupt pulse from the handler restores the saved level, so sources that were masked while the handler ran can be taken again. The acknowledge timeout and the handler-table base come from inputs, so software setup elsewhere can program them.

Top module: `prio_vic`

## Requirements
- R1: After reset, `int_req_o`, `dev_ack_o`, `handler_valid_o` and `bus_err_o` are all low, and `cur_lvl_o` is 0, which is the foreground level.
- R2: Request line i has priority N_LINES-i. From IDLE, the block takes the lowest-numbered pending line whose priority is strictly above `cur_lvl_o`. It asserts `int_req_o` one cycle later and holds it, with `dev_ack_o` low, until a cycle in which `cpu_ack_i` is high.
- R3: A line whose priority is less than or equal to `cur_lvl_o` produces no request.
- R4: The cycle after `int_req_o` and `cpu_ack_i` are both high, `int_req_o` drops and `dev_ack_o` is one-hot on the chosen source. Bit i selects line i, and bit N_LINES selects the non-maskable source.
- R5: A cycle in which `dev_ack_o` is high and `vec_valid_i` is high is followed by a one-cycle `handler_valid_o` pulse. In that cycle `handler_addr_o` = `tbl_base_i` + 4×`vec_i`, modulo 2^ADDR_W, and `dev_ack_o` is low.
- R6: `dev_ack_o` stays high for at most `tmo_limit_i`+1 cycles. If no vector arrives in any of those cycles, the next cycle shows a one-cycle `bus_err_o` pulse with `dev_ack_o` low, and `cur_lvl_o` does not change.
- R7: A rising edge on `nmi_i` is latched. The latched edge outranks every request line and is taken whatever `cur_lvl_o` is. Its handler level is N_LINES+1. The latch is cleared when that source gets a handler or a bus error.
- R8: On the `handler_valid_o` pulse, `cur_lvl_o` becomes the priority of the source just served, and the previous level is saved on a stack of depth N_LINES+2. If the stack is full, its oldest entry is discarded.
- R9: An `eoi_i` pulse restores the most recently saved level on the next cycle. With nothing saved, `cur_lvl_o` becomes 0.
- R10: `cur_lvl_o` changes only on a handler entry or after an `eoi_i` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | N_LINES | Level request lines, line 0 most urgent |
| nmi_i | input | 1 | Non-maskable request, edge sensitive |
| tmo_limit_i | input | TMO_W | Vector wait limit in cycles |
| tbl_base_i | input | ADDR_W | Handler table base address |
| int_req_o | output | 1 | Interrupt request to CPU |
| cpu_ack_i | input | 1 | CPU ready to take the interrupt |
| dev_ack_o | output | N_LINES+1 | One-hot acknowledge to the chosen device |
| vec_valid_i | input | 1 | Device vector present |
| vec_i | input | VEC_W | Device vector |
| handler_valid_o | output | 1 | Handler address valid pulse |
| handler_addr_o | output | ADDR_W | Handler table entry address |
| bus_err_o | output | 1 | Vector timeout pulse |
| eoi_i | input | 1 | End-of-interrupt pulse |
| cur_lvl_o | output | clog2(N_LINES+2) | Running priority level |

## Verification
Raising every line at once shows whether the lowest-numbered line wins the selection. Raising one line at exactly the running level, and then one step above it, shows whether the masking compare is strict. A non-maskable edge that arrives with all lines raised, and at the top maskable level, separates the bypass path from the ordinary compare. Timeouts of zero, and vectors that arrive on the last allowed acknowledge cycle, mark the edge of the timeout window. Random line patterns at random stack depths, with end-of-interrupt pulses mixed in, compare the level history against a stack model.

// File: rtl/prio_vic.sv
module prio_vic #(
  parameter int N_LINES = 8,
  parameter int VEC_W   = 8,
  parameter int ADDR_W  = 16,
  parameter int TMO_W   = 8,
  parameter int STK_DEPTH = N_LINES + 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_LINES-1:0]          irq_i,
  input  logic                        nmi_i,
  input  logic [TMO_W-1:0]            tmo_limit_i,
  input  logic [ADDR_W-1:0]           tbl_base_i,
  output logic                        int_req_o,
  input  logic                        cpu_ack_i,
  output logic [N_LINES:0]            dev_ack_o,
  input  logic                        vec_valid_i,
  input  logic [VEC_W-1:0]            vec_i,
  output logic                        handler_valid_o,
  output logic [ADDR_W-1:0]           handler_addr_o,
  output logic                        bus_err_o,
  input  logic                        eoi_i,
  output logic [$clog2(N_LINES+2)-1:0] cur_lvl_o
);
  localparam int LVL_W   = $clog2(N_LINES + 2);
  localparam int IDX_W   = $clog2(N_LINES + 1);
  localparam int SP_W    = $clog2(STK_DEPTH + 1);
  localparam int NMI_LVL = N_LINES + 1;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  st_t state;

  logic [LVL_W-1:0] cur_lvl, cand_lvl, pick_lvl;
  logic [IDX_W-1:0] cand_idx, pick_idx;
  logic             pick_ok;
  logic             nmi_q, nmi_pend;
  logic [TMO_W-1:0] cnt;
  logic [LVL_W-1:0] stk [STK_DEPTH];
  logic [SP_W-1:0]  sp;

  wire timed_out = (state == S_WAIT) && !vec_valid_i && (cnt == tmo_limit_i);
  wire do_push   = (state == S_WAIT) && vec_valid_i;
  wire do_pop    = eoi_i && !do_push;
  wire nmi_done  = (do_push || timed_out) && (cand_idx == IDX_W'(N_LINES));

  always_comb begin
    pick_ok  = 1'b0;
    pick_idx = '0;
    pick_lvl = '0;
    if (nmi_pend) begin
      pick_ok  = 1'b1;
      pick_idx = IDX_W'(N_LINES);
      pick_lvl = LVL_W'(NMI_LVL);
    end else begin
      for (int i = N_LINES - 1; i >= 0; i--) begin
        if (irq_i[i] && (LVL_W'(N_LINES - i) > cur_lvl)) begin
          pick_ok  = 1'b1;
          pick_idx = IDX_W'(i);
          pick_lvl = LVL_W'(N_LINES - i);
        end
      end
    end
  end

  assign int_req_o = (state == S_REQ);
  assign dev_ack_o = (state == S_WAIT) ? ({{N_LINES{1'b0}}, 1'b1} << cand_idx) : '0;
  assign cur_lvl_o = cur_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state           <= S_IDLE;
      cand_idx        <= '0;
      cand_lvl        <= '0;
      cnt             <= '0;
      nmi_q           <= 1'b0;
      nmi_pend        <= 1'b0;
      handler_valid_o <= 1'b0;
      handler_addr_o  <= '0;
      bus_err_o       <= 1'b0;
    end else begin
      nmi_q           <= nmi_i;
      nmi_pend        <= (nmi_i && !nmi_q) || (nmi_pend && !nmi_done);
      handler_valid_o <= 1'b0;
      bus_err_o       <= 1'b0;
      case (state)
        S_IDLE: if (pick_ok) begin
          state    <= S_REQ;
          cand_idx <= pick_idx;
          cand_lvl <= pick_lvl;
        end
        S_REQ: if (cpu_ack_i) begin
          state <= S_WAIT;
          cnt   <= '0;
        end
        S_WAIT: begin
          if (vec_valid_i) begin
            handler_valid_o <= 1'b1;
            handler_addr_o  <= tbl_base_i + ADDR_W'({vec_i, 2'b00});
            state           <= S_IDLE;
          end else if (timed_out) begin
            bus_err_o <= 1'b1;
            state     <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_lvl <= '0;
      sp      <= '0;
      for (int k = 0; k < STK_DEPTH; k++) stk[k] <= '0;
    end else if (do_push) begin
      cur_lvl <= cand_lvl;
      stk[0]  <= cur_lvl;
      for (int k = 1; k < STK_DEPTH; k++) stk[k] <= stk[k-1];
      if (sp != SP_W'(STK_DEPTH)) sp <= sp + 1'b1;
    end else if (do_pop) begin
      cur_lvl <= (sp != '0) ? stk[0] : '0;
      for (int k = 0; k < STK_DEPTH - 1; k++) stk[k] <= stk[k+1];
      stk[STK_DEPTH-1] <= '0;
      if (sp != '0) sp <= sp - 1'b1;
    end
  end
endmodule

// File: rtl/prio_vic_chk.sv
module prio_vic_chk #(
  parameter int N_LINES = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          int_req_o,
  input logic                          cpu_ack_i,
  input logic [N_LINES:0]              dev_ack_o,
  input logic                          vec_valid_i,
  input logic                          handler_valid_o,
  input logic                          bus_err_o,
  input logic                          eoi_i,
  input logic [$clog2(N_LINES+2)-1:0]  cur_lvl_o
);
  localparam int LVL_W   = $clog2(N_LINES + 2);
  localparam int NMI_LVL = N_LINES + 1;

  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    int_req_o && !cpu_ack_i |=> int_req_o && (dev_ack_o == '0));

  a_r4_ack_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    int_req_o && cpu_ack_i |=> !int_req_o && (dev_ack_o != '0));

  a_r4_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_ack_o));

  a_r5_vector_done: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack_o != '0) && vec_valid_i |=> handler_valid_o && !bus_err_o && (dev_ack_o == '0));

  a_r6_err_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_o |-> ($past(dev_ack_o) != '0) && (dev_ack_o == '0) && !handler_valid_o);

  a_r8_level_rises: assert property (@(posedge clk) disable iff (!rst_n)
    handler_valid_o && (cur_lvl_o != LVL_W'(NMI_LVL)) |-> cur_lvl_o > $past(cur_lvl_o));

  a_r10_level_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !handler_valid_o && !$past(eoi_i) |-> $stable(cur_lvl_o));
endmodule

bind prio_vic prio_vic_chk #(.N_LINES(N_LINES)) u_chk (.*);

// File: tb/prio_vic_tb_top.sv
`timescale 1ns/1ps
module prio_vic_tb_top;
  localparam int N = 8;
  localparam int DEPTH = N + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic        nmi = 1'b0;
  logic [7:0]  tmo = 8'd3;
  logic [15:0] base = 16'h1000;
  logic        int_req;
  logic        cpu_ack = 1'b0;
  logic [N:0]  dev_ack;
  logic        vec_valid = 1'b0;
  logic [7:0]  vec = '0;
  logic        hv;
  logic [15:0] haddr;
  logic        berr;
  logic        eoi = 1'b0;
  logic [3:0]  lvl;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  int mlvl = 0;
  int stkq[$];

  always #2.5 clk = ~clk;

  prio_vic dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .nmi_i(nmi), .tmo_limit_i(tmo),
    .tbl_base_i(base), .int_req_o(int_req), .cpu_ack_i(cpu_ack), .dev_ack_o(dev_ack),
    .vec_valid_i(vec_valid), .vec_i(vec), .handler_valid_o(hv), .handler_addr_o(haddr),
    .bus_err_o(berr), .eoi_i(eoi), .cur_lvl_o(lvl)
  );

  function automatic int f_pick(logic [N-1:0] p, bit n, int cl);
    if (n) return N;
    for (int i = 0; i < N; i++) if (p[i] && (N - i) > cl) return i;
    return -1;
  endfunction

  function automatic int f_prio(int idx);
    return (idx == N) ? N + 1 : N - idx;
  endfunction

  function automatic logic [15:0] f_addr(logic [15:0] b, logic [7:0] v);
    return b + {6'b0, v, 2'b00};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    end
  endtask

  task automatic do_eoi;
    eoi = 1'b1;
    tick;
    eoi = 1'b0;
    if (stkq.size() > 0) mlvl = stkq.pop_front();
    else mlvl = 0;
    chk("R9 level after eoi", 32'(lvl), 32'(mlvl));
  endtask

  task automatic episode(logic [N-1:0] pat, bit use_nmi, int t, bit give_vec, int d, int hold);
    int exp;
    logic [7:0] v;
    tmo = 8'(t);
    base = 16'($urandom);
    exp = f_pick(pat, use_nmi, mlvl);
    if (use_nmi) begin
      nmi = 1'b1; tick; nmi = 1'b0; irq = pat; tick;
    end else begin
      irq = pat; tick; tick;
    end
    if (exp < 0) begin
      chk("R3 masked request", 32'(int_req), 0);
      chk("R3 no ack when masked", 32'(dev_ack), 0);
      irq = '0;
      tick;
      return;
    end
    chk("R2 request raised", 32'(int_req), 1);
    chk("R2 no early ack", 32'(dev_ack), 0);
    for (int h = 0; h < hold; h++) begin
      tick;
      chk("R2 request held", 32'(int_req), 1);
      chk("R2 ack waits for cpu", 32'(dev_ack), 0);
    end
    cpu_ack = 1'b1; tick; cpu_ack = 1'b0;
    chk("R4 one-hot ack", 32'(dev_ack), 32'(1) << exp);
    chk("R4 request dropped", 32'(int_req), 0);
    if (give_vec) begin
      repeat (d) tick;
      chk("R6 ack inside window", 32'(dev_ack), 32'(1) << exp);
      v = 8'($urandom);
      vec = v; vec_valid = 1'b1; tick; vec_valid = 1'b0; irq = '0;
      chk("R5 handler pulse", 32'(hv), 1);
      chk("R5 handler address", 32'(haddr), 32'(f_addr(base, v)));
      chk("R5 ack released", 32'(dev_ack), 0);
      chk("R6 no error on vector", 32'(berr), 0);
      stkq.push_front(mlvl);
      if (stkq.size() > DEPTH) void'(stkq.pop_back());
      mlvl = f_prio(exp);
      chk(exp == N ? "R7 nmi level" : "R8 level raised", 32'(lvl), 32'(mlvl));
      tick;
      chk("R5 pulse is single", 32'(hv), 0);
    end else begin
      repeat (t) tick;
      chk("R6 ack still on", 32'(dev_ack), 32'(1) << exp);
      chk("R6 no early error", 32'(berr), 0);
      tick; irq = '0;
      chk("R6 bus error", 32'(berr), 1);
      chk("R6 ack dropped", 32'(dev_ack), 0);
      chk("R6 no handler", 32'(hv), 0);
      chk("R10 level kept on error", 32'(lvl), 32'(mlvl));
      tick;
      chk("R6 error single", 32'(berr), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    report;
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    chk("R1 reset req", 32'(int_req), 0);
    chk("R1 reset ack", 32'(dev_ack), 0);
    chk("R1 reset handler", 32'(hv), 0);
    chk("R1 reset error", 32'(berr), 0);
    chk("R1 reset level", 32'(lvl), 0);

    episode(8'hFF, 0, 3, 1, 0, 0);
    do_eoi;
    episode(8'h80, 0, 2, 1, 2, 1);
    episode(8'h80, 0, 2, 1, 0, 0);
    episode(8'h40, 0, 4, 1, 4, 2);
    do_eoi; do_eoi; do_eoi;
    episode(8'h01, 0, 0, 0, 0, 0);
    episode(8'h01, 0, 5, 0, 0, 1);
    episode(8'h01, 0, 0, 1, 0, 0);
    episode(8'hFF, 1, 3, 1, 1, 0);
    episode(8'h00, 1, 1, 0, 0, 0);
    do_eoi; do_eoi;
    repeat (4) tick;
    chk("R10 level idle", 32'(lvl), 32'(mlvl));

    for (int e = 0; e < 400; e++) begin
      int t;
      t = int'($urandom % 8);
      episode(N'($urandom), ($urandom % 8) == 0, t, ($urandom % 4) != 0,
              int'($urandom % (t + 1)), int'($urandom % 3));
      if (($urandom % 2) == 0) do_eoi;
      if (($urandom % 8) == 0) begin
        repeat (2) tick;
        chk("R10 level idle", 32'(lvl), 32'(mlvl));
      end
    end
    while (mlvl != 0 || stkq.size() > 0) do_eoi;
    do_eoi;
    report;
    $finish;
  end
endmodule